// File: doc/BRIEF.md
# VBI Line Qualifier and Capture

This block sits on the byte bus of a video decoder during the vertical blanking part of each field. It samples the bus, the active-low vertical sync and the active-low horizontal sync on the rising edge of the 27 MHz clock. It counts lines from the end of each vertical sync pulse. It expects one ancillary packet per line, starting with the byte that arrives alongside the first high sample of horizontal sync. Each packet has a four-byte header and then a counted run of data bytes.

The header is checked for the ID byte, the count prefix and odd parity. A line is then kept or dropped according to three filters:

- a line/pixel window set by an offset in lines and a length in clock cycles;
- a window on the line number that the decoder reports;
- a data-type match.

A line whose type is a raw-sample type is also dropped unless raw capture is enabled.

Kept lines are written, one byte per cycle, to consecutive addresses of an external 1 KB buffer through a simple write port. Bytes are written as they arrive. When a line is rejected part-way through, the write pointer is rewound so that the next line overwrites the rejected one. A one-cycle strobe marks the end of the capture range in each field. A sticky flag records any write that did not fit in the buffer.

Top module: `vbi_capture`

## Requirements
- R1: While reset is held, and on the first cycle after it, `wr_en`, `field_done` and `overflow` are 0.
- R2: A packet is dropped, and the pointer rewound to the address where its first byte went, if any of these checks fails:
  - byte 1 is 0x85;
  - bits 7:6 of byte 2 are binary 10;
  - bytes 3 and 4 each have an odd number of ones.
- R3: A kept packet is written to consecutive addresses in arrival order: 4 header bytes, then N data bytes, where N is bits 5:0 of byte 2 (N=0 means header only). A byte sampled at clock edge k appears on the write port after edge k+1. The first byte of a packet is the one sampled with the first high `hsync_n` of a line.
- R4: When `ctrl[6]` is set, two limits apply:
  - A line is captured only if its index exceeds `win_ofs`. The index counts rising edges of `hsync_n` since the rising edge of `vsync_n`, so the first line is index 1.
  - A byte at pixel position p is accepted only if p < `win_len`, where p is the number of clocks since that `hsync_n` rise (the ID byte is p=0). A packet cut by this limit is dropped and rewound.
- R5: When `ctrl[4]` is set, a line is kept only if its reported line number lies in 2 to 21. The line number is bits 5:0 of byte 3 (number bits 8:3) joined with bits 6:4 of byte 4 (number bits 2:0). When this window and the R4 window are both enabled, a line must pass both.
- R6: When `ctrl[7]` is set, a line is kept only if bits 3:0 of byte 4 equal `ctrl[3:0]`.
- R7: Lines of type 0110, 0111 or 1111 are dropped unless `ctrl[5]` is set.
- R8: A falling edge of `vsync_n` resets the write pointer to 0 and abandons any packet in progress.
- R9: A write whose address would be 1024 or beyond is suppressed and sets `overflow`, which stays set until reset.
- R10: `field_done` is high for exactly one cycle, in the cycle after the clock edge that processes the `hsync_n` rise beginning line index 22.
- R11: An `hsync_n` rise during an unfinished packet discards that packet. The new line's packet starts at the discarded packet's first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz video byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_n | input | 1 | Active-low vertical sync |
| hsync_n | input | 1 | Active-low horizontal sync |
| vid_data | input | 8 | Decoder byte bus |
| ctrl | input | 8 | Filter control byte |
| win_len | input | 11 | Line window length in clocks |
| win_ofs | input | 9 | Line window offset in lines |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 10 | Buffer write address |
| wr_data | output | 8 | Buffer write byte |
| field_done | output | 1 | End-of-capture strobe |
| overflow | output | 1 | Sticky buffer overflow flag |

## Verification
The hardest state to reach from the ports is the overflow boundary. It requires more than a thousand accepted bytes inside one field without a vertical sync in between. The stimulus therefore sends a field of long lines that each carry the largest packet count, so the pointer reaches the buffer end part-way through a packet.

The rewind paths also need care. Packets are cut by a horizontal sync, by the pixel window and by a vertical sync while their header or data is still arriving. A cycle-accurate reference model then confirms the exact addresses that the following lines reuse.

// File: rtl/vbi_capture.sv
module vbi_capture #(
  parameter int AW         = 10,
  parameter int PW         = 11,
  parameter int OW         = 9,
  parameter int CW         = 6,
  parameter int FIRST_LINE = 2,
  parameter int LAST_LINE  = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync_n,
  input  logic          hsync_n,
  input  logic [7:0]    vid_data,
  input  logic [7:0]    ctrl,
  input  logic [PW-1:0] win_len,
  input  logic [OW-1:0] win_ofs,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          field_done,
  output logic          overflow
);
  localparam int LCW = OW + 1;
  localparam int NLW = 3 + CW;
  localparam logic [7:0] PKT_ID = 8'h85;

  typedef enum logic [1:0] {IDLE, HDR, DATA} st_t;

  logic          vs_q, hs_q, vs_p, hs_p;
  logic [7:0]    d_q, hb3;
  logic [PW-1:0] pix_r, pix;
  logic [LCW-1:0] line_cnt, n_line;
  logic [AW:0]   ptr, base, wptr, nbase;
  st_t           st, nst;
  logic [1:0]    hidx, nidx;
  logic [CW-1:0] rem, nrem;
  logic          a_wr, a_rw;

  wire vs_fall = vs_p & ~vs_q;
  wire vs_rise = ~vs_p & vs_q;
  wire hs_rise = ~hs_p & hs_q;

  assign pix    = hs_rise ? '0 : pix_r;
  assign n_line = hs_rise ? ((line_cnt == '1) ? line_cnt : line_cnt + 1'b1) : line_cnt;

  wire line_ok = ~ctrl[6] | (n_line > {1'b0, win_ofs});
  wire in_pix  = ~ctrl[6] | (pix < win_len);

  wire [NLW-1:0] hdr_line = {hb3[CW-1:0], d_q[6:4]};
  wire [3:0]     hdr_type = d_q[3:0];
  wire is_raw  = (hdr_type == 4'b0110) | (hdr_type == 4'b0111) | (hdr_type == 4'b1111);
  wire vbi_ok  = ~ctrl[4] | ((hdr_line >= NLW'(FIRST_LINE)) & (hdr_line <= NLW'(LAST_LINE)));
  wire type_ok = ~ctrl[7] | (hdr_type == ctrl[3:0]);
  wire raw_ok  = ~is_raw | ctrl[5];
  wire keep    = (^d_q) & vbi_ok & type_ok & raw_ok;

  always_comb begin
    a_wr  = 1'b0;
    a_rw  = 1'b0;
    nst   = st;
    nidx  = hidx;
    nrem  = rem;
    nbase = base;
    wptr  = ptr;
    if (vs_fall) begin
      nst = IDLE;
    end else if (hs_rise) begin
      nbase = (st != IDLE) ? base : ptr;
      wptr  = nbase;
      if (line_ok && in_pix && d_q == PKT_ID) begin
        a_wr = 1'b1;
        nst  = HDR;
        nidx = 2'd1;
      end else begin
        a_rw = 1'b1;
        nst  = IDLE;
      end
    end else if (st != IDLE) begin
      if (!in_pix) begin
        a_rw = 1'b1;
        nst  = IDLE;
      end else if (st == HDR) begin
        case (hidx)
          2'd1: if (d_q[7:6] == 2'b10) begin
                  a_wr = 1'b1; nidx = 2'd2; nrem = d_q[CW-1:0];
                end else begin
                  a_rw = 1'b1; nst = IDLE;
                end
          2'd2: if (^d_q) begin
                  a_wr = 1'b1; nidx = 2'd3;
                end else begin
                  a_rw = 1'b1; nst = IDLE;
                end
          default: if (keep) begin
                  a_wr = 1'b1;
                  nst  = (rem == '0) ? IDLE : DATA;
                end else begin
                  a_rw = 1'b1; nst = IDLE;
                end
        endcase
      end else begin
        a_wr = 1'b1;
        nrem = rem - 1'b1;
        if (rem == CW'(1)) nst = IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q <= 1'b1; hs_q <= 1'b1; vs_p <= 1'b1; hs_p <= 1'b1;
      d_q <= '0; hb3 <= '0;
      pix_r <= '0; line_cnt <= '0;
      ptr <= '0; base <= '0;
      st <= IDLE; hidx <= '0; rem <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      field_done <= 1'b0; overflow <= 1'b0;
    end else begin
      vs_q <= vsync_n; hs_q <= hsync_n; d_q <= vid_data;
      vs_p <= vs_q;    hs_p <= hs_q;
      pix_r <= (pix == '1) ? pix : pix + 1'b1;
      if (vs_rise)      line_cnt <= '0;
      else if (hs_rise) line_cnt <= n_line;
      field_done <= hs_rise & ~vs_fall & (n_line == LCW'(LAST_LINE + 1));
      if (st == HDR && hidx == 2'd2) hb3 <= d_q;
      st <= nst; hidx <= nidx; rem <= nrem; base <= nbase;
      wr_en <= 1'b0;
      if (vs_fall) begin
        ptr <= '0;
      end else if (a_rw) begin
        ptr <= nbase;
      end else if (a_wr) begin
        if (wptr[AW]) begin
          overflow <= 1'b1;
          ptr      <= wptr;
        end else begin
          wr_en   <= 1'b1;
          wr_addr <= wptr[AW-1:0];
          wr_data <= d_q;
          ptr     <= wptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vbi_capture_chk.sv
module vbi_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic vsync_n,
  input logic hsync_n,
  input logic wr_en,
  input logic field_done,
  input logic overflow
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_en && !field_done && !overflow));

  p_vsfall_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> ##2 !wr_en);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |=> !field_done);

  p_done_after_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> ($past(hsync_n, 2) && !$past(hsync_n, 3)));
endmodule

bind vbi_capture vbi_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .hsync_n(hsync_n),
  .wr_en(wr_en), .field_done(field_done), .overflow(overflow)
);

// File: tb/vbi_capture_test.sv
module vbi_capture_test;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_n = 1'b1, hsync_n = 1'b1;
  logic [7:0] vid_data = 8'h10, ctrl = 8'h00;
  logic [10:0] win_len = '0;
  logic [8:0] win_ofs = '0;
  logic wr_en, field_done, overflow;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0] mem [0:1023];

  always #5 clk = ~clk;

  vbi_capture uut (
    .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .hsync_n(hsync_n),
    .vid_data(vid_data), .ctrl(ctrl), .win_len(win_len), .win_ofs(win_ofs),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .field_done(field_done), .overflow(overflow)
  );

  // reference model state
  int m_ptr, m_start, m_st, m_rem, m_lines, m_pix;
  logic [7:0] m_b3, s_d;
  logic s_vs, s_hs, p_vs, p_hs;
  logic e_wr, e_done, e_ovf;
  int e_addr;
  logic [7:0] e_data;
  string m_tag;

  task automatic m_put(input logic [7:0] b);
    if (m_ptr >= 1024) begin
      e_ovf = 1'b1;
      m_tag = "R9";
    end else begin
      e_wr = 1'b1; e_addr = m_ptr; e_data = b; m_ptr++;
    end
  endtask

  task automatic m_drop(input string t);
    m_ptr = m_start; m_st = 0; m_tag = t;
  endtask

  always @(posedge clk) begin : model
    bit vf, vr, hr, lok, pok;
    int pix, nl, ln;
    logic [7:0] b;
    logic [3:0] ty;
    if (!rst_n) begin
      s_vs = 1; s_hs = 1; p_vs = 1; p_hs = 1; s_d = 0;
      m_ptr = 0; m_start = 0; m_st = 0; m_rem = 0; m_lines = 0; m_pix = 0; m_b3 = 0;
      e_wr = 0; e_done = 0; e_ovf = 0; e_addr = 0; e_data = 0; m_tag = "R1";
    end else begin
      vf = p_vs && !s_vs; vr = !p_vs && s_vs; hr = !p_hs && s_hs;
      b = s_d;
      e_wr = 0; m_tag = "R3";
      pix = hr ? 0 : m_pix;
      m_pix = (pix < 2047) ? pix + 1 : pix;
      nl = hr ? ((m_lines < 1023) ? m_lines + 1 : m_lines) : m_lines;
      e_done = hr && !vf && nl == 22;
      if (vr) m_lines = 0; else m_lines = nl;
      lok = !ctrl[6] || nl > int'(win_ofs);
      pok = !ctrl[6] || pix < int'(win_len);
      if (vf) begin
        m_ptr = 0; m_st = 0; m_tag = "R8";
      end else if (hr) begin
        if (m_st != 0) begin m_ptr = m_start; m_tag = "R11"; end
        m_start = m_ptr;
        if (!lok || !pok) begin m_st = 0; m_tag = "R4"; end
        else if (b != 8'h85) m_st = 0;
        else begin m_put(b); m_st = 1; end
      end else if (m_st != 0) begin
        if (!pok) m_drop("R4");
        else if (m_st == 1) begin
          if (b[7:6] == 2'b10) begin m_rem = b[5:0]; m_put(b); m_st = 2; end
          else m_drop("R2");
        end else if (m_st == 2) begin
          if (^b) begin m_b3 = b; m_put(b); m_st = 3; end
          else m_drop("R2");
        end else if (m_st == 3) begin
          ln = {m_b3[5:0], b[6:4]};
          ty = b[3:0];
          if (!(^b)) m_drop("R2");
          else if (ctrl[4] && (ln < 2 || ln > 21)) m_drop("R5");
          else if (ctrl[7] && ty != ctrl[3:0]) m_drop("R6");
          else if ((ty == 4'd6 || ty == 4'd7 || ty == 4'd15) && !ctrl[5]) m_drop("R7");
          else begin m_put(b); m_st = (m_rem == 0) ? 0 : 4; end
        end else begin
          m_put(b); m_rem--;
          if (m_rem == 0) m_st = 0;
        end
      end
      p_vs = s_vs; p_hs = s_hs;
      s_vs = vsync_n; s_hs = hsync_n; s_d = vid_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (wr_en !== e_wr || (e_wr && (wr_addr !== e_addr[9:0] || wr_data !== e_data))) begin
        fails++;
        $display("FAIL %s write: got en=%b addr=%0d data=%h, expected en=%b addr=%0d data=%h",
                 m_tag, wr_en, wr_addr, wr_data, e_wr, e_addr, e_data);
      end
      checks++;
      if (field_done !== e_done) begin
        fails++;
        $display("FAIL R10 field_done: got %b expected %b", field_done, e_done);
      end
      checks++;
      if (overflow !== e_ovf) begin
        fails++;
        $display("FAIL R9 overflow: got %b expected %b", overflow, e_ovf);
      end
      if (wr_en === 1'b1) mem[wr_addr] = wr_data;
      if (field_done === 1'b1) done_cnt++;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bq_t pkt(input int cnt, input int ln, input int ty);
    bq_t q;
    logic [6:0] l3, l4;
    l3 = {1'b0, 6'(ln >> 3)};
    l4 = {3'(ln), 4'(ty)};
    q.push_back(8'h85);
    q.push_back({2'b10, 6'(cnt)});
    q.push_back({~^l3, l3});
    q.push_back({~^l4, l4});
    for (int k = 0; k < cnt; k++) q.push_back(8'hA0 + 8'(k));
    return q;
  endfunction

  int lines_sent = 0;

  task automatic send_line(input bq_t pk, input int len);
    repeat (2) begin
      @(negedge clk); hsync_n = 1'b0; vid_data = 8'h10;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hsync_n = 1'b1;
      vid_data = (i < pk.size()) ? pk[i] : 8'h10;
    end
    lines_sent++;
  endtask

  task automatic begin_field();
    repeat (3) begin
      @(negedge clk); vsync_n = 1'b0; hsync_n = 1'b1; vid_data = 8'h10;
    end
    @(negedge clk); vsync_n = 1'b1;
    repeat (2) @(negedge clk);
    lines_sent = 0;
    done_cnt = 0;
  endtask

  task automatic end_field(input int exp_done);
    bq_t e;
    while (lines_sent < 23) send_line(e, 20);
    repeat (3) @(negedge clk);
    check("R10 done pulses per field", done_cnt, exp_done);
  endtask

  initial begin
    bq_t q;
    repeat (4) @(negedge clk);
    check("R1 wr_en in reset", int'(wr_en), 0);
    check("R1 field_done in reset", int'(field_done), 0);
    check("R1 overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_en after reset", int'(wr_en), 0);

    // field A: header checks and rewind (R2, R3)
    begin_field();
    send_line(pkt(3, 5, 0), 20);
    send_line(pkt(0, 6, 1), 20);
    q = pkt(1, 7, 0); q[0] = 8'h84; send_line(q, 20);
    q = pkt(2, 7, 0); q[2] = q[2] ^ 8'h80; send_line(q, 20);
    send_line(pkt(1, 8, 0), 20);
    q = pkt(1, 9, 0); q[1] = 8'hC1; send_line(q, 20);
    q = pkt(1, 9, 0); q[3] = q[3] ^ 8'h01; send_line(q, 20);
    end_field(1);
    check("R3 first ID at 0", int'(mem[0]), 8'h85);
    check("R3 last data of line 1", int'(mem[6]), 8'hA2);
    check("R3 zero-count byte", int'(mem[8]), 8'h80);
    check("R2 rewound ID at 11", int'(mem[11]), 8'h85);
    check("R2 rewound data at 15", int'(mem[15]), 8'hA0);

    // field B: line/pixel window (R4)
    ctrl = 8'h40; win_ofs = 9'd3; win_len = 11'd8;
    begin_field();
    repeat (3) send_line(pkt(2, 3, 0), 20);
    send_line(pkt(2, 4, 0), 20);
    send_line(pkt(5, 5, 0), 20);
    send_line(pkt(3, 6, 0), 20);
    end_field(1);
    check("R4 kept line at 0", int'(mem[0]), 8'h85);
    check("R4 cut line overwritten", int'(mem[6]), 8'h85);

    // field C: VBI window and type filter (R5, R6)
    ctrl = 8'h95;
    begin_field();
    send_line(pkt(1, 1, 5), 20);
    send_line(pkt(1, 10, 5), 20);
    send_line(pkt(1, 21, 5), 20);
    send_line(pkt(1, 22, 5), 20);
    send_line(pkt(1, 10, 4), 20);
    end_field(1);

    // field D: both windows intersect (R4, R5)
    ctrl = 8'h50; win_ofs = 9'd2; win_len = 11'd30;
    begin_field();
    send_line(pkt(1, 10, 0), 20);
    send_line(pkt(1, 10, 0), 20);
    send_line(pkt(1, 25, 0), 20);
    send_line(pkt(1, 12, 0), 20);
    end_field(1);

    // field E: raw types (R7)
    ctrl = 8'h00;
    begin_field();
    send_line(pkt(2, 3, 6), 20);
    send_line(pkt(2, 3, 7), 20);
    send_line(pkt(2, 3, 15), 20);
    send_line(pkt(2, 3, 3), 20);
    ctrl = 8'h20;
    send_line(pkt(2, 4, 6), 20);
    send_line(pkt(2, 4, 7), 20);
    send_line(pkt(2, 4, 15), 20);
    end_field(1);

    // field F: hsync cut (R11) and vsync cut (R8)
    ctrl = 8'h00;
    begin_field();
    send_line(pkt(10, 3, 0), 8);
    send_line(pkt(2, 4, 0), 20);
    check("R11 restart at cut start", int'(mem[0]), 8'h85);
    check("R11 second packet count", int'(mem[1]), 8'h82);
    send_line(pkt(10, 5, 0), 8);
    begin_field();
    send_line(pkt(1, 3, 2), 20);
    check("R8 pointer back to zero", int'(mem[3]) & 15, 2);
    end_field(1);

    // field G: overflow (R9)
    begin_field();
    repeat (17) send_line(pkt(63, 3, 0), 70);
    end_field(1);
    check("R9 overflow sticky set", int'(overflow), 1);

    begin_field();
    send_line(pkt(1, 3, 0), 20);
    end_field(1);
    check("R9 overflow stays set", int'(overflow), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule